// File: doc/BRIEF.md
# Interrupt Stack Frame Builder

This block builds the stack frame that a protected-mode interrupt leaves behind, and then produces the register state the handler starts with. A start strobe latches the dispatch class, the gate width, the gate kind, the error-code flag and all old and new register values. The block compares the room on the target stack against the size the frame needs. It then issues one stack write per cycle through a word/dword write port, and finally commits the new segment, pointer, flag and privilege state. Descriptor validation happens upstream: the block trusts the class, the target privilege and the new stack pointer it is given.

Three dispatch classes are supported. A same-privilege entry stays on the current stack. A privilege-raising entry first switches to the new stack and saves the old one. An entry that leaves virtual-8086 mode also saves the four data segment selectors and then clears them. If the stack room is short, the block reports a stack fault with the matching selector. In that case it performs no write and leaves its committed state untouched.

Top module: `ifb_frame_builder`

## Requirements
- R1: After a synchronous active-low reset, every committed output is zero, and wr_en, done and fault are low.
- R2: The frame needs (slot count) x (slot bytes) of room. A slot is 4 bytes for a 32-bit gate (gate32=1) and 2 bytes for a 16-bit gate. The slot count is 3, 5 or 9 for classes 0 (same privilege), 1 (privilege raise) and 2 (virtual-8086 exit), plus one when has_err=1. Class 3 behaves as class 0. When room is below the need, a fault is reported. When room equals the need, the frame is built.
- R3: A fault is a one-cycle pulse on fault, two clock edges after start is sampled. It comes with no write and with no change to any committed output. fault_sel is 0 for class 0 and new_ss for classes 1 and 2.
- R4: For class 0, the writes are old EFLAGS, old CS, old EIP, and then the error code when has_err=1.
- R5: For class 1, the writes are old SS, old ESP, old EFLAGS, old CS, old EIP, and then the error code when present.
- R6: For class 2, the writes are old GS, FS, DS, ES, old SS, old ESP, old EFLAGS, old CS, old EIP, and then the error code when present.
- R7: For a 32-bit gate, every write has wr_dword=1 and selectors are zero-extended to 32 bits. For a 16-bit gate, every write has wr_dword=0 and carries only the low 16 bits of the value, with the upper bits zero.
- R8: The stack pointer starts at old_esp for class 0 and at new_esp otherwise. It is decremented by the slot size before each write, and wr_addr carries the decremented value. out_esp is the pointer after the last write.
- R9: out_eflags is old EFLAGS with TF (bit 8), NT (bit 14), RF (bit 16) and VM (bit 17) cleared. IF (bit 9) is cleared only when int_gate=1.
- R10: out_cpl is tgt_dpl for classes 1 and 2 and cur_cpl for class 0. out_cs is gate_cs with its low two bits replaced by out_cpl.
- R11: out_eip is gate_eip for a 32-bit gate and gate_eip with its upper 16 bits cleared for a 16-bit gate.
- R12: out_ss is new_ss for classes 1 and 2 and old_ss for class 0. out_ds, out_es, out_fs and out_gs are zero after class 2 and pass the old values through otherwise.
- R13: done is a one-cycle pulse on the edge after the last write, that is 2+N edges after start for N writes. A start seen while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame; sampled only when idle |
| dcls | input | 2 | Dispatch class: 0 same privilege, 1 privilege raise, 2 virtual-8086 exit |
| gate32 | input | 1 | 1 for a 32-bit gate, 0 for a 16-bit gate |
| has_err | input | 1 | An error code is pushed |
| int_gate | input | 1 | 1 for an interrupt gate, 0 for a trap gate |
| tgt_dpl | input | 2 | Privilege of the target code segment |
| cur_cpl | input | 2 | Current privilege level |
| room | input | ROOM_W | Bytes free on the stack the frame goes to |
| old_ss | input | 16 | Current stack selector |
| old_esp | input | 32 | Current stack pointer |
| old_eflags | input | 32 | Current flags |
| old_cs | input | 16 | Current code selector |
| old_eip | input | 32 | Return instruction pointer |
| old_ds | input | 16 | Current DS |
| old_es | input | 16 | Current ES |
| old_fs | input | 16 | Current FS |
| old_gs | input | 16 | Current GS |
| new_ss | input | 16 | Stack selector from the task state for a privilege change |
| new_esp | input | 32 | Stack pointer from the task state for a privilege change |
| gate_cs | input | 16 | Handler code selector |
| gate_eip | input | 32 | Handler entry offset |
| err_code | input | 32 | Error code value |
| wr_en | output | 1 | Stack write strobe |
| wr_dword | output | 1 | 1 for a 4-byte write, 0 for a 2-byte write |
| wr_addr | output | 32 | Stack pointer value for this write |
| wr_data | output | 32 | Write data |
| done | output | 1 | Frame complete and state committed |
| fault | output | 1 | Stack room too small |
| fault_sel | output | 16 | Selector reported with the stack fault |
| out_ss | output | 16 | Committed stack selector |
| out_esp | output | 32 | Committed stack pointer |
| out_eflags | output | 32 | Committed flags |
| out_cs | output | 16 | Committed code selector |
| out_eip | output | 32 | Committed instruction pointer |
| out_ds | output | 16 | Committed DS |
| out_es | output | 16 | Committed ES |
| out_fs | output | 16 | Committed FS |
| out_gs | output | 16 | Committed GS |
| out_cpl | output | 2 | Committed privilege level |

## Verification
The hardest situation to reach is a start strobe that arrives in the middle of a long frame. Reaching it needs a virtual-8086 exit, the longest push list, with its sequence already running. The stimulus re-pulses start a few cycles into such a frame and changes every register input at the same moment. The scoreboard still expects only the original writes and the original commit. Room values are also placed exactly at the need and one byte below it, for several class and width pairs, so that both sides of the boundary are seen.

// File: rtl/ifb_pkg.sv
// Shared types, widths and helpers for the interrupt frame builder.
// Assumes slot kinds are numbered in push order so a frame is a contiguous range.
package ifb_pkg;
    parameter int unsigned REG_W  = 32;
    parameter int unsigned SEL_W  = 16;
    parameter int unsigned HALF_W = REG_W / 2;
    parameter int unsigned PL_W   = 2;

    localparam int unsigned FL_TF = 8;
    localparam int unsigned FL_IF = 9;
    localparam int unsigned FL_NT = 14;
    localparam int unsigned FL_RF = 16;
    localparam int unsigned FL_VM = 17;

    typedef enum logic [1:0] {
        CLS_SAME = 2'd0,
        CLS_RAISE = 2'd1,
        CLS_V86X = 2'd2,
        CLS_RSVD = 2'd3
    } disp_cls_e;

    typedef enum logic [3:0] {
        SL_GS  = 4'd0,
        SL_FS  = 4'd1,
        SL_DS  = 4'd2,
        SL_ES  = 4'd3,
        SL_SS  = 4'd4,
        SL_SP  = 4'd5,
        SL_FL  = 4'd6,
        SL_CS  = 4'd7,
        SL_IP  = 4'd8,
        SL_ERR = 4'd9
    } slot_e;

    typedef struct packed {
        disp_cls_e        cls;
        logic             gate32;
        logic             has_err;
        logic             int_gate;
        logic [PL_W-1:0]  tgt_dpl;
        logic [PL_W-1:0]  cur_cpl;
        logic [SEL_W-1:0] old_ss;
        logic [REG_W-1:0] old_esp;
        logic [REG_W-1:0] old_eflags;
        logic [SEL_W-1:0] old_cs;
        logic [REG_W-1:0] old_eip;
        logic [SEL_W-1:0] old_ds;
        logic [SEL_W-1:0] old_es;
        logic [SEL_W-1:0] old_fs;
        logic [SEL_W-1:0] old_gs;
        logic [SEL_W-1:0] new_ss;
        logic [REG_W-1:0] new_esp;
        logic [SEL_W-1:0] gate_cs;
        logic [REG_W-1:0] gate_eip;
        logic [REG_W-1:0] err;
    } ifb_ctx_t;

    typedef struct packed {
        logic [SEL_W-1:0] ss;
        logic [REG_W-1:0] esp;
        logic [REG_W-1:0] eflags;
        logic [SEL_W-1:0] cs;
        logic [REG_W-1:0] eip;
        logic [SEL_W-1:0] ds;
        logic [SEL_W-1:0] es;
        logic [SEL_W-1:0] fs;
        logic [SEL_W-1:0] gs;
        logic [PL_W-1:0]  cpl;
    } ifb_arch_t;

    // True when the class switches to a new stack before pushing.
    function automatic logic is_priv_change(disp_cls_e c);
        return (c == CLS_RAISE) || (c == CLS_V86X);
    endfunction

    // First slot of the push range for a class.
    function automatic slot_e first_slot(disp_cls_e c);
        case (c)
            CLS_V86X:  return SL_GS;
            CLS_RAISE: return SL_SS;
            default:   return SL_FL;
        endcase
    endfunction

    // Last slot of the push range.
    function automatic slot_e final_slot(logic err_present);
        return err_present ? SL_ERR : SL_IP;
    endfunction
endpackage

// File: rtl/ifb_room_check.sv
// Computes the frame size for a class, gate width and error flag,
// and flags a shortfall against the free room. Pure combinational.
module ifb_room_check
    import ifb_pkg::*;
#(
    parameter int unsigned ROOM_W = 16
) (
    input  disp_cls_e         cls,
    input  logic              gate32,
    input  logic              has_err,
    input  logic [ROOM_W-1:0] room,
    output logic              short_room
);
    localparam int unsigned CNT_W = 5;

    logic [CNT_W-1:0]  n_slots;
    logic [ROOM_W-1:0] need_bytes;

    // Slot count is the inclusive span of the push range.
    always_comb begin
        n_slots = CNT_W'(final_slot(has_err)) - CNT_W'(first_slot(cls)) + CNT_W'(1);
    end

    // Bytes needed and the comparison against room.
    always_comb begin
        need_bytes = gate32 ? (ROOM_W'(n_slots) << 2) : (ROOM_W'(n_slots) << 1);
        short_room = room < need_bytes;
    end
endmodule

// File: rtl/ifb_slot_mux.sv
// Selects the value written for one slot of the frame and fits it to the
// gate width. Assumes the context was latched at start and stays stable.
module ifb_slot_mux
    import ifb_pkg::*;
(
    input  ifb_ctx_t          ctx,
    input  slot_e             slot,
    output logic [REG_W-1:0]  data
);
    logic [REG_W-1:0] raw;

    // Pick the source register for the slot.
    always_comb begin
        case (slot)
            SL_GS:   raw = REG_W'(ctx.old_gs);
            SL_FS:   raw = REG_W'(ctx.old_fs);
            SL_DS:   raw = REG_W'(ctx.old_ds);
            SL_ES:   raw = REG_W'(ctx.old_es);
            SL_SS:   raw = REG_W'(ctx.old_ss);
            SL_SP:   raw = ctx.old_esp;
            SL_FL:   raw = ctx.old_eflags;
            SL_CS:   raw = REG_W'(ctx.old_cs);
            SL_IP:   raw = ctx.old_eip;
            default: raw = ctx.err;
        endcase
    end

    // Narrow gates write only the low half.
    always_comb begin
        data = ctx.gate32 ? raw : {{(REG_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
    end
endmodule

// File: rtl/ifb_commit_calc.sv
// Derives the register state the handler starts with from the latched
// context and the stack pointer left after the last push.
module ifb_commit_calc
    import ifb_pkg::*;
(
    input  ifb_ctx_t          ctx,
    input  logic [REG_W-1:0]  final_sp,
    output ifb_arch_t         nxt
);
    logic             priv;
    logic             v86x;
    logic [PL_W-1:0]  new_cpl;
    logic [REG_W-1:0] fl;

    // Classify the entry.
    always_comb begin
        priv    = is_priv_change(ctx.cls);
        v86x    = (ctx.cls == CLS_V86X);
        new_cpl = priv ? ctx.tgt_dpl : ctx.cur_cpl;
    end

    // Clear the trace, nesting, resume and v86 flags; IF for interrupt gates.
    always_comb begin
        fl        = ctx.old_eflags;
        fl[FL_TF] = 1'b0;
        fl[FL_NT] = 1'b0;
        fl[FL_RF] = 1'b0;
        fl[FL_VM] = 1'b0;
        if (ctx.int_gate) fl[FL_IF] = 1'b0;
    end

    // Assemble the committed state.
    always_comb begin
        nxt.ss     = priv ? ctx.new_ss : ctx.old_ss;
        nxt.esp    = final_sp;
        nxt.eflags = fl;
        nxt.cs     = (ctx.gate_cs & ~SEL_W'((1 << PL_W) - 1)) | SEL_W'(new_cpl);
        nxt.eip    = ctx.gate32 ? ctx.gate_eip
                                : {{(REG_W-HALF_W){1'b0}}, ctx.gate_eip[HALF_W-1:0]};
        nxt.ds     = v86x ? '0 : ctx.old_ds;
        nxt.es     = v86x ? '0 : ctx.old_es;
        nxt.fs     = v86x ? '0 : ctx.old_fs;
        nxt.gs     = v86x ? '0 : ctx.old_gs;
        nxt.cpl    = new_cpl;
    end
endmodule

// File: rtl/ifb_frame_builder.sv
// Interrupt stack frame builder. Latches a request on start, checks stack
// room, issues one write per cycle for each slot, then commits new state.
// Assumes descriptors were already validated and new_esp is meaningful for
// privilege-changing classes. Nothing is committed on a fault.
module ifb_frame_builder
    import ifb_pkg::*;
#(
    parameter int unsigned ROOM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        dcls,
    input  logic              gate32,
    input  logic              has_err,
    input  logic              int_gate,
    input  logic [PL_W-1:0]   tgt_dpl,
    input  logic [PL_W-1:0]   cur_cpl,
    input  logic [ROOM_W-1:0] room,
    input  logic [SEL_W-1:0]  old_ss,
    input  logic [REG_W-1:0]  old_esp,
    input  logic [REG_W-1:0]  old_eflags,
    input  logic [SEL_W-1:0]  old_cs,
    input  logic [REG_W-1:0]  old_eip,
    input  logic [SEL_W-1:0]  old_ds,
    input  logic [SEL_W-1:0]  old_es,
    input  logic [SEL_W-1:0]  old_fs,
    input  logic [SEL_W-1:0]  old_gs,
    input  logic [SEL_W-1:0]  new_ss,
    input  logic [REG_W-1:0]  new_esp,
    input  logic [SEL_W-1:0]  gate_cs,
    input  logic [REG_W-1:0]  gate_eip,
    input  logic [REG_W-1:0]  err_code,
    output logic              wr_en,
    output logic              wr_dword,
    output logic [REG_W-1:0]  wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic              done,
    output logic              fault,
    output logic [SEL_W-1:0]  fault_sel,
    output logic [SEL_W-1:0]  out_ss,
    output logic [REG_W-1:0]  out_esp,
    output logic [REG_W-1:0]  out_eflags,
    output logic [SEL_W-1:0]  out_cs,
    output logic [REG_W-1:0]  out_eip,
    output logic [SEL_W-1:0]  out_ds,
    output logic [SEL_W-1:0]  out_es,
    output logic [SEL_W-1:0]  out_fs,
    output logic [SEL_W-1:0]  out_gs,
    output logic [PL_W-1:0]   out_cpl
);
    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_PUSH} fsm_e;

    fsm_e             state_q;
    ifb_ctx_t         ctx_d, ctx_q;
    logic [ROOM_W-1:0] room_q;
    slot_e            slot_q;
    logic [REG_W-1:0] sp_q;
    logic [REG_W-1:0] sp_next;
    logic [REG_W-1:0] step;
    logic             short_room;
    logic [REG_W-1:0] slot_data;
    ifb_arch_t        arch_q, arch_nxt;
    logic             done_q, fault_q;
    logic [SEL_W-1:0] fsel_q;

    // Gather the request inputs into one context record.
    always_comb begin
        ctx_d.cls        = disp_cls_e'(dcls);
        ctx_d.gate32     = gate32;
        ctx_d.has_err    = has_err;
        ctx_d.int_gate   = int_gate;
        ctx_d.tgt_dpl    = tgt_dpl;
        ctx_d.cur_cpl    = cur_cpl;
        ctx_d.old_ss     = old_ss;
        ctx_d.old_esp    = old_esp;
        ctx_d.old_eflags = old_eflags;
        ctx_d.old_cs     = old_cs;
        ctx_d.old_eip    = old_eip;
        ctx_d.old_ds     = old_ds;
        ctx_d.old_es     = old_es;
        ctx_d.old_fs     = old_fs;
        ctx_d.old_gs     = old_gs;
        ctx_d.new_ss     = new_ss;
        ctx_d.new_esp    = new_esp;
        ctx_d.gate_cs    = gate_cs;
        ctx_d.gate_eip   = gate_eip;
        ctx_d.err        = err_code;
    end

    ifb_room_check #(.ROOM_W(ROOM_W)) u_room (
        .cls        (ctx_q.cls),
        .gate32     (ctx_q.gate32),
        .has_err    (ctx_q.has_err),
        .room       (room_q),
        .short_room (short_room)
    );

    ifb_slot_mux u_mux (
        .ctx  (ctx_q),
        .slot (slot_q),
        .data (slot_data)
    );

    ifb_commit_calc u_commit (
        .ctx      (ctx_q),
        .final_sp (sp_next),
        .nxt      (arch_nxt)
    );

    // Pre-decremented pointer for the write in flight.
    always_comb begin
        step    = ctx_q.gate32 ? REG_W'(4) : REG_W'(2);
        sp_next = sp_q - step;
    end

    // Sequencer: latch, room check, push loop and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            room_q  <= '0;
            slot_q  <= SL_GS;
            sp_q    <= '0;
            arch_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            fsel_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctx_q   <= ctx_d;
                        room_q  <= room;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (short_room) begin
                        fault_q <= 1'b1;
                        fsel_q  <= is_priv_change(ctx_q.cls) ? ctx_q.new_ss : '0;
                        state_q <= ST_IDLE;
                    end else begin
                        slot_q  <= first_slot(ctx_q.cls);
                        sp_q    <= is_priv_change(ctx_q.cls) ? ctx_q.new_esp : ctx_q.old_esp;
                        state_q <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    sp_q   <= sp_next;
                    slot_q <= slot_e'(slot_q + 4'd1);
                    if (slot_q == final_slot(ctx_q.has_err)) begin
                        arch_q  <= arch_nxt;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the write port and committed outputs.
    always_comb begin
        wr_en      = (state_q == ST_PUSH);
        wr_dword   = ctx_q.gate32;
        wr_addr    = sp_next;
        wr_data    = slot_data;
        done       = done_q;
        fault      = fault_q;
        fault_sel  = fsel_q;
        out_ss     = arch_q.ss;
        out_esp    = arch_q.esp;
        out_eflags = arch_q.eflags;
        out_cs     = arch_q.cs;
        out_eip    = arch_q.eip;
        out_ds     = arch_q.ds;
        out_es     = arch_q.es;
        out_fs     = arch_q.fs;
        out_gs     = arch_q.gs;
        out_cpl    = arch_q.cpl;
    end
endmodule

// File: rtl/ifb_frame_builder_chk.sv
// Property checker for the frame builder, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module ifb_frame_builder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_dword,
    input logic [31:0] wr_addr,
    input logic        done,
    input logic        fault,
    input logic [31:0] out_esp,
    input logic [31:0] out_eflags,
    input logic [15:0] out_cs,
    input logic [15:0] out_ss,
    input logic [1:0]  out_cpl
);
    // R3: a fault never coincides with a write.
    assert_fault_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_en);

    // R3: the fault strobe lasts one cycle.
    assert_fault_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R3: committed state is untouched when a fault is reported.
    assert_fault_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(out_esp) && $stable(out_eflags) && $stable(out_cs) && $stable(out_ss)));

    // R13: done and fault are never raised together, and done lasts one cycle.
    assert_done_fault_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault}));
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: back-to-back writes step the pointer down by one slot.
    assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - (wr_dword ? 32'd4 : 32'd2)));

    // R8: the committed pointer is the address of the last write.
    assert_final_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(wr_en)) |-> (out_esp == $past(wr_addr)));

    // R9: cleared flags are zero after a completed frame.
    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_eflags[8] == 1'b0 && out_eflags[14] == 1'b0
                  && out_eflags[16] == 1'b0 && out_eflags[17] == 1'b0));

    // R10: selector privilege bits follow the committed level.
    assert_cs_rpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_cs[1:0] == out_cpl));
endmodule

bind ifb_frame_builder ifb_frame_builder_chk u_ifb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_dword   (wr_dword),
    .wr_addr    (wr_addr),
    .done       (done),
    .fault      (fault),
    .out_esp    (out_esp),
    .out_eflags (out_eflags),
    .out_cs     (out_cs),
    .out_ss     (out_ss),
    .out_cpl    (out_cpl)
);

// File: tb/test_ifb_frame_builder.sv
// Scoreboard bench: the driver queues expected writes and results, the
// monitor pops and compares them at the falling edge.
module test_ifb_frame_builder;
    localparam int CLK_NS   = 10;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  dcls = '0;
    logic        gate32 = 1'b0, has_err = 1'b0, int_gate = 1'b0;
    logic [1:0]  tgt_dpl = '0, cur_cpl = '0;
    logic [15:0] room = '0;
    logic [15:0] old_ss = '0, old_cs = '0, old_ds = '0, old_es = '0, old_fs = '0, old_gs = '0;
    logic [15:0] new_ss = '0, gate_cs = '0;
    logic [31:0] old_esp = '0, old_eflags = '0, old_eip = '0, new_esp = '0, gate_eip = '0, err_code = '0;
    logic        wr_en, wr_dword, done, fault;
    logic [31:0] wr_addr, wr_data;
    logic [15:0] fault_sel, out_ss, out_cs, out_ds, out_es, out_fs, out_gs;
    logic [31:0] out_esp, out_eflags, out_eip;
    logic [1:0]  out_cpl;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        dw;
        string       tag;
    } wr_t;

    typedef struct {
        logic        flt;
        logic [15:0] sel;
        logic [15:0] ss, cs, ds, es, fs, gs;
        logic [31:0] esp, eflags, eip;
        logic [1:0]  cpl;
        int          at;
        string       tag;
    } res_t;

    wr_t  wq[$];
    res_t rq[$];
    res_t cur;

    ifb_frame_builder i_ifb_frame_builder (
        .clk(clk), .rst_n(rst_n), .start(start), .dcls(dcls), .gate32(gate32),
        .has_err(has_err), .int_gate(int_gate), .tgt_dpl(tgt_dpl), .cur_cpl(cur_cpl),
        .room(room), .old_ss(old_ss), .old_esp(old_esp), .old_eflags(old_eflags),
        .old_cs(old_cs), .old_eip(old_eip), .old_ds(old_ds), .old_es(old_es),
        .old_fs(old_fs), .old_gs(old_gs), .new_ss(new_ss), .new_esp(new_esp),
        .gate_cs(gate_cs), .gate_eip(gate_eip), .err_code(err_code),
        .wr_en(wr_en), .wr_dword(wr_dword), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .fault(fault), .fault_sel(fault_sel), .out_ss(out_ss),
        .out_esp(out_esp), .out_eflags(out_eflags), .out_cs(out_cs), .out_eip(out_eip),
        .out_ds(out_ds), .out_es(out_es), .out_fs(out_fs), .out_gs(out_gs),
        .out_cpl(out_cpl)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cmp_state(input res_t e);
        string r8, r9, r10, r11, r12;
        r8 = e.flt ? "R3" : "R8";
        r9 = e.flt ? "R3" : "R9";
        r10 = e.flt ? "R3" : "R10";
        r11 = e.flt ? "R3" : "R11";
        r12 = e.flt ? "R3" : "R12";
        check(r8,  "out_esp",    out_esp,    e.esp);
        check(r9,  "out_eflags", out_eflags, e.eflags);
        check(r10, "out_cs",     32'(out_cs),  32'(e.cs));
        check(r10, "out_cpl",    32'(out_cpl), 32'(e.cpl));
        check(r11, "out_eip",    out_eip,    e.eip);
        check(r12, "out_ss",     32'(out_ss), 32'(e.ss));
        check(r12, "out_ds",     32'(out_ds), 32'(e.ds));
        check(r12, "out_es",     32'(out_es), 32'(e.es));
        check(r12, "out_fs",     32'(out_fs), 32'(e.fs));
        check(r12, "out_gs",     32'(out_gs), 32'(e.gs));
    endtask

    // Monitor: compare every write and every completion against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (wq.size() == 0) begin
                    check("R13", "unexpected write", 32'd1, 32'd0);
                end else begin
                    wr_t w;
                    w = wq.pop_front();
                    check(w.tag, "wr_data", wr_data, w.data);
                    check("R8", "wr_addr", wr_addr, w.addr);
                    check("R7", "wr_dword", 32'(wr_dword), 32'(w.dw));
                end
            end
            if (done || fault) begin
                if (rq.size() == 0) begin
                    check("R13", "unexpected completion", 32'd1, 32'd0);
                end else begin
                    res_t e;
                    e = rq.pop_front();
                    check(e.tag, "fault flag", 32'(fault), 32'(e.flt));
                    check(e.flt ? "R3" : "R13", "completion cycle", 32'(cyc), 32'(e.at));
                    if (e.flt) check("R3", "fault_sel", 32'(fault_sel), 32'(e.sel));
                    else check("R13", "writes left at done", 32'(wq.size()), 32'd0);
                    cmp_state(e);
                end
            end
        end
    end

    // Fit a value to the slot width of the gate.
    function automatic logic [31:0] fit(input logic g32, input logic [31:0] v);
        return g32 ? v : {16'h0, v[15:0]};
    endfunction

    // Driver: set inputs, queue expectations, strobe start, wait for the end.
    task automatic run(input logic [1:0] c, input logic g32, input logic er,
                       input logic ig, input int rm, input logic [15:0] seed,
                       input bit poke, input string tag);
        logic [31:0] vals[$];
        int          sz, need, k;
        logic [31:0] sp;
        res_t        e;
        string       ord;
        old_ss     = 16'h2000 + seed;
        old_esp    = 32'h0001_0000 + 32'(seed) * 16;
        old_eflags = 32'h0003_4300 | 32'(seed[7:0]);
        old_cs     = 16'h0010 + seed;
        old_eip    = 32'h8000_1234 + 32'(seed);
        old_ds     = 16'h0023 + seed;
        old_es     = 16'h0033 + seed;
        old_fs     = 16'h0043 + seed;
        old_gs     = 16'h0053 + seed;
        new_ss     = 16'h0068 + (seed << 3);
        new_esp    = 32'h0004_0000 - 32'(seed) * 8;
        gate_cs    = 16'h0083 + (seed << 3);
        gate_eip   = 32'hC0DE_0000 + 32'(seed) * 3;
        err_code   = 32'hEE00_0000 | 32'(seed);
        tgt_dpl    = seed[1:0];
        cur_cpl    = seed[3:2];
        dcls = c; gate32 = g32; has_err = er; int_gate = ig; room = 16'(rm);

        if (c == 2'd2) begin
            vals.push_back(32'(old_gs)); vals.push_back(32'(old_fs));
            vals.push_back(32'(old_ds)); vals.push_back(32'(old_es));
        end
        if (c == 2'd1 || c == 2'd2) begin
            vals.push_back(32'(old_ss)); vals.push_back(old_esp);
        end
        vals.push_back(old_eflags); vals.push_back(32'(old_cs)); vals.push_back(old_eip);
        if (er) vals.push_back(err_code);
        ord = (c == 2'd2) ? "R6" : (c == 2'd1) ? "R5" : "R4";

        sz   = g32 ? 4 : 2;
        need = vals.size() * sz;
        k    = cyc;
        if (rm < need) begin
            e     = cur;
            e.flt = 1'b1;
            e.sel = (c == 2'd1 || c == 2'd2) ? new_ss : 16'h0;
            e.at  = k + 2;
            e.tag = {"R2 ", tag};
            rq.push_back(e);
        end else begin
            sp = (c == 2'd1 || c == 2'd2) ? new_esp : old_esp;
            foreach (vals[i]) begin
                wr_t w;
                sp     = sp - 32'(sz);
                w.addr = sp;
                w.data = fit(g32, vals[i]);
                w.dw   = g32;
                w.tag  = (g32 ? ord : "R7");
                wq.push_back(w);
            end
            e.flt    = 1'b0;
            e.sel    = '0;
            e.esp    = sp;
            e.eflags = old_eflags & ~(32'h0003_4100 | (ig ? 32'h0000_0200 : 32'h0));
            e.cpl    = (c == 2'd1 || c == 2'd2) ? tgt_dpl : cur_cpl;
            e.cs     = {gate_cs[15:2], e.cpl};
            e.eip    = fit(g32, gate_eip);
            e.ss     = (c == 2'd1 || c == 2'd2) ? new_ss : old_ss;
            e.ds     = (c == 2'd2) ? 16'h0 : old_ds;
            e.es     = (c == 2'd2) ? 16'h0 : old_es;
            e.fs     = (c == 2'd2) ? 16'h0 : old_fs;
            e.gs     = (c == 2'd2) ? 16'h0 : old_gs;
            e.at     = k + 2 + vals.size();
            e.tag    = {"R2 ", tag};
            rq.push_back(e);
            cur = e;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R13: start during a running frame, with every input changed.
            repeat (2) @(negedge clk);
            start = 1'b1; old_esp = old_esp ^ 32'h0000_0F00; new_esp = new_esp ^ 32'h0000_0F00;
            old_gs = ~old_gs; err_code = ~err_code; dcls = 2'd0; room = 16'h0;
            @(negedge clk);
            start = 1'b0;
        end
        while (rq.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur = '{flt: 1'b0, sel: 16'h0, ss: 16'h0, cs: 16'h0, ds: 16'h0, es: 16'h0,
                fs: 16'h0, gs: 16'h0, esp: 32'h0, eflags: 32'h0, eip: 32'h0,
                cpl: 2'd0, at: 0, tag: "R1"};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1", "wr_en", 32'(wr_en), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "fault", 32'(fault), 32'd0);
        check("R1", "out_esp", out_esp, 32'h0);
        check("R1", "out_eflags", out_eflags, 32'h0);
        check("R1", "out_cs", 32'(out_cs), 32'h0);

        run(2'd0, 1'b1, 1'b1, 1'b1, 16, 16'h0005, 1'b0, "same 32 err at need");
        run(2'd0, 1'b1, 1'b0, 1'b1, 11, 16'h0006, 1'b0, "same 32 short");
        run(2'd1, 1'b1, 1'b0, 1'b0, 20, 16'h0009, 1'b0, "raise 32 trap at need");
        run(2'd1, 1'b0, 1'b1, 1'b1, 12, 16'h1F2E, 1'b0, "raise 16 err at need");
        run(2'd1, 1'b0, 1'b1, 1'b1, 11, 16'h000A, 1'b0, "raise 16 short");
        run(2'd2, 1'b1, 1'b1, 1'b1, 40, 16'h0010, 1'b1, "v86 32 err busy start");
        run(2'd2, 1'b0, 1'b0, 1'b0, 18, 16'hA5C4, 1'b0, "v86 16 at need");
        run(2'd2, 1'b1, 1'b0, 1'b1, 35, 16'h0014, 1'b0, "v86 32 short");
        run(2'd0, 1'b0, 1'b0, 1'b0, 6, 16'h7ABC, 1'b0, "same 16 at need");
        run(2'd3, 1'b1, 1'b0, 1'b1, 100, 16'h0021, 1'b0, "class 3 as same");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule